// File: doc/BRIEF.md
# Command Queue Fetch Pointer Controller

This block produces the stream of read addresses that a command queue engine uses to pull 64-bit command words out of memory. Software configures it with single-cycle message pulses: a start-relocation message, a command message carrying either an absolute end address or a byte offset, and, for circular operation, a new producer position together with a move pulse. The controller keeps one read pointer and presents it on a request port. Each accepted request moves the pointer forward by one 8-byte command.

Three modes are selected at `mode_i`. In absolute mode each command message names a complete range. In offset mode, successive ranges follow one another in memory, and offsets that arrive while busy are added together. In circular mode the pointer follows a software-owned producer position inside a bounded region and wraps at the top of that region. A snapshot pulse copies the current read pointer into a register that software can read.

Top module: `cmdq_fetch_ptr`

## Requirements
- R1: After a synchronous active-low reset, `req_o` and `busy_o` are low and `snap_addr_o` is zero.
- R2: With `mode_i`=0 (absolute), a command message accepted while idle issues requests at `start_addr_i`, +8, +16 and so on, one address per grant, up to but not including `end_addr_i`. Equal start and end addresses issue nothing.
- R3: In absolute mode, command messages that arrive while busy replace each other, so only the newest range is kept. That range runs after the current range ends, and `busy_o` stays high in between.
- R4: While `req_o` is high and `req_gnt_i` is low, `req_addr_o` holds its value.
- R5: With `mode_i`=1 (offset), a command message accepted while idle fetches from the stored resume address up to that address plus `offset_i`. The resume address then moves to the end of that range.
- R6: In offset mode, offsets that arrive while busy are summed. Once the current range ends, the sum runs as one contiguous extension that starts where the previous range ended.
- R7: In offset mode, a start message accepted while idle sets the resume address to `start_addr_i`. A start message that arrives while `busy_o` is high is ignored.
- R8: With `mode_i`=2 (circular), a start message sets the region base, the read pointer and the producer position to `start_addr_i`, and stops fetching. A command message sets the exclusive region top to `end_addr_i`. A move pulse loads `ring_wptr_i`, and requests are then issued while the read pointer differs from the producer position.
- R9: In circular mode, when the read pointer plus 8 equals the region top, the next address is the region base.
- R10: A `snap_trig_i` pulse copies the read pointer of that cycle into `snap_addr_o`, and the copy is visible in the following cycle. If a grant falls in the same cycle, the address copied is the one being granted.
- R11: `busy_o` is high while requests are outstanding or an absolute or offset range is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 0 absolute, 1 offset, 2 circular |
| start_set_i | input | 1 | Start-relocation message pulse |
| start_addr_i | input | AW | Start address / circular base |
| cmd_msg_i | input | 1 | Command message pulse |
| end_addr_i | input | AW | Absolute end (exclusive) or circular top |
| offset_i | input | AW | Byte offset for offset mode |
| ring_move_i | input | 1 | Producer move pulse |
| ring_wptr_i | input | AW | New producer position |
| snap_trig_i | input | 1 | Read-pointer snapshot pulse |
| req_gnt_i | input | 1 | Memory accepts the current request |
| req_o | output | 1 | Fetch request valid |
| req_addr_o | output | AW | Fetch address |
| busy_o | output | 1 | Range active or pending |
| snap_addr_o | output | AW | Captured read pointer |

## Verification
A snapshot pulse and a grant can land in the same cycle. Both act on the read pointer: one copies it and the other advances it. The bench sets up this case in circular mode by holding the grant low so that the address stays still, then raising the grant and the snapshot pulse on the same falling edge. On the next falling edge it requires that the snapshot equals the address that was granted and that the request address has already moved on by 8. A second snapshot taken while the grant is held low then has to return the new address.

// File: rtl/cmdq_fp_pkg.sv
// Package: shared mode encoding and command word size for the fetch
// pointer controller. Assumes byte addressing with 8-byte commands.
package cmdq_fp_pkg;
    typedef enum logic [1:0] {
        CQ_ABS  = 2'd0,
        CQ_OFS  = 2'd1,
        CQ_CIRC = 2'd2
    } cq_mode_e;

    localparam int unsigned CMD_BYTES = 8;
endpackage

// File: rtl/cmdq_msg_ctl.sv
// Module: software message handling. Holds the pending absolute range, the
// offset sum and resume address, and the circular region bounds.
// Issues a load to the sequencer only when the sequencer is idle.
// Assumes the mode is changed only while the block is not busy.
module cmdq_msg_ctl
    import cmdq_fp_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          start_set_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          cmd_msg_i,
    input  logic [AW-1:0] end_addr_i,
    input  logic [AW-1:0] offset_i,
    input  logic          ring_move_i,
    input  logic [AW-1:0] ring_wptr_i,
    input  logic          seq_idle_i,
    output logic          ld_valid_o,
    output logic [AW-1:0] ld_start_o,
    output logic [AW-1:0] ld_end_o,
    output logic          pend_o,
    output logic [AW-1:0] circ_base_o,
    output logic [AW-1:0] circ_top_o,
    output logic [AW-1:0] circ_wptr_o,
    output logic          circ_arm_o
);
    cq_mode_e       mode;
    logic           abs_pv;
    logic [AW-1:0]  abs_ps, abs_pe;
    logic [AW-1:0]  ofs_resume, ofs_sum, ofs_total, ofs_base;
    logic           ofs_reloc;

    assign mode = cq_mode_e'(mode_i);

    // Purpose: relocation is legal only in offset mode with nothing running or pending.
    assign ofs_reloc = (mode == CQ_OFS) && start_set_i && seq_idle_i && (ofs_sum == '0);
    assign ofs_base  = ofs_reloc ? start_addr_i : ofs_resume;
    assign ofs_total = ofs_sum + (cmd_msg_i ? offset_i : '0);
    assign pend_o    = abs_pv || (ofs_sum != '0);

    // Purpose: decide whether the sequencer gets a new range this cycle.
    always_comb begin
        ld_valid_o = 1'b0;
        ld_start_o = ofs_base;
        ld_end_o   = ofs_base;
        case (mode)
            CQ_OFS: begin
                if (seq_idle_i && (ofs_total != '0)) begin
                    ld_valid_o = 1'b1;
                    ld_end_o   = ofs_base + ofs_total;
                end
            end
            CQ_CIRC: begin
                if (seq_idle_i && start_set_i) begin
                    ld_valid_o = 1'b1;
                    ld_start_o = start_addr_i;
                    ld_end_o   = start_addr_i;
                end
            end
            default: begin
                if (seq_idle_i && cmd_msg_i) begin
                    ld_valid_o = 1'b1;
                    ld_start_o = start_addr_i;
                    ld_end_o   = end_addr_i;
                end else if (seq_idle_i && abs_pv) begin
                    ld_valid_o = 1'b1;
                    ld_start_o = abs_ps;
                    ld_end_o   = abs_pe;
                end
            end
        endcase
    end

    // Purpose: absolute mode keeps only the newest range received while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abs_pv <= 1'b0;
            abs_ps <= '0;
            abs_pe <= '0;
        end else if (mode != CQ_OFS && mode != CQ_CIRC) begin
            if (seq_idle_i) begin
                abs_pv <= 1'b0;
            end else if (cmd_msg_i) begin
                abs_pv <= 1'b1;
                abs_ps <= start_addr_i;
                abs_pe <= end_addr_i;
            end
        end
    end

    // Purpose: offset mode resume address and the sum of offsets received while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_resume <= '0;
            ofs_sum    <= '0;
        end else if (mode == CQ_OFS) begin
            if (ld_valid_o) begin
                ofs_resume <= ld_end_o;
            end else if (ofs_reloc) begin
                ofs_resume <= start_addr_i;
            end
            if (seq_idle_i) begin
                ofs_sum <= '0;
            end else if (cmd_msg_i) begin
                ofs_sum <= ofs_sum + offset_i;
            end
        end
    end

    // Purpose: circular region bounds, producer position and run enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            circ_base_o <= '0;
            circ_top_o  <= '0;
            circ_wptr_o <= '0;
            circ_arm_o  <= 1'b0;
        end else if (mode == CQ_CIRC) begin
            if (start_set_i && seq_idle_i) begin
                circ_base_o <= start_addr_i;
                circ_wptr_o <= start_addr_i;
                circ_arm_o  <= 1'b0;
            end else if (ring_move_i) begin
                circ_wptr_o <= ring_wptr_i;
                circ_arm_o  <= 1'b1;
            end
            if (cmd_msg_i) begin
                circ_top_o <= end_addr_i;
            end
        end
    end
endmodule

// File: rtl/cmdq_fetch_seq.sv
// Module: read pointer sequencer. Steps the pointer by one command on every
// grant. Linear ranges stop at an exclusive end, and the circular pointer
// wraps at the region top. Assumes loads arrive only while idle.
module cmdq_fetch_seq
    import cmdq_fp_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          circ_i,
    input  logic          ld_valid_i,
    input  logic [AW-1:0] ld_start_i,
    input  logic [AW-1:0] ld_end_i,
    input  logic [AW-1:0] circ_base_i,
    input  logic [AW-1:0] circ_top_i,
    input  logic [AW-1:0] circ_wptr_i,
    input  logic          circ_arm_i,
    input  logic          req_gnt_i,
    output logic          req_o,
    output logic [AW-1:0] rd_ptr_o,
    output logic          idle_o
);
    localparam logic [AW-1:0] STEP = AW'(CMD_BYTES);

    logic [AW-1:0] rd_ptr, lin_end, inc_ptr, nxt_ptr;
    logic          lin_act;

    // Purpose: next address, folding back to the base at the circular top.
    assign inc_ptr = rd_ptr + STEP;
    assign nxt_ptr = (circ_i && (inc_ptr == circ_top_i)) ? circ_base_i : inc_ptr;

    assign req_o    = circ_i ? (circ_arm_i && (rd_ptr != circ_wptr_i)) : lin_act;
    assign idle_o   = !req_o;
    assign rd_ptr_o = rd_ptr;

    // Purpose: load a new range or advance the pointer on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            lin_end <= '0;
            lin_act <= 1'b0;
        end else if (ld_valid_i) begin
            rd_ptr  <= ld_start_i;
            lin_end <= ld_end_i;
            lin_act <= !circ_i && (ld_start_i != ld_end_i);
        end else if (req_o && req_gnt_i) begin
            rd_ptr <= nxt_ptr;
            if (!circ_i && (inc_ptr == lin_end)) begin
                lin_act <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmdq_rd_snap.sv
// Module: captures the read pointer on a software trigger so it can be read
// back later. Assumes the pointer input is the value of the current cycle.
module cmdq_rd_snap #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [AW-1:0] ptr_i,
    output logic [AW-1:0] snap_o
);
    // Purpose: hold the pointer value seen in the trigger cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_o <= '0;
        end else if (trig_i) begin
            snap_o <= ptr_i;
        end
    end
endmodule

// File: rtl/cmdq_fetch_ptr.sv
// Module: top of the command queue fetch pointer controller. Connects the
// message handler, the pointer sequencer and the snapshot register.
// Assumes 8-byte aligned addresses and a mode that is stable while busy.
module cmdq_fetch_ptr
    import cmdq_fp_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          start_set_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          cmd_msg_i,
    input  logic [AW-1:0] end_addr_i,
    input  logic [AW-1:0] offset_i,
    input  logic          ring_move_i,
    input  logic [AW-1:0] ring_wptr_i,
    input  logic          snap_trig_i,
    input  logic          req_gnt_i,
    output logic          req_o,
    output logic [AW-1:0] req_addr_o,
    output logic          busy_o,
    output logic [AW-1:0] snap_addr_o
);
    logic          seq_idle, ld_valid, pend, circ_arm;
    logic [AW-1:0] ld_start, ld_end, circ_base, circ_top, circ_wptr;
    logic          circ_mode;

    assign circ_mode = (cq_mode_e'(mode_i) == CQ_CIRC);

    cmdq_msg_ctl #(.AW(AW)) u_msg (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .start_set_i(start_set_i), .start_addr_i(start_addr_i),
        .cmd_msg_i(cmd_msg_i), .end_addr_i(end_addr_i), .offset_i(offset_i),
        .ring_move_i(ring_move_i), .ring_wptr_i(ring_wptr_i),
        .seq_idle_i(seq_idle),
        .ld_valid_o(ld_valid), .ld_start_o(ld_start), .ld_end_o(ld_end),
        .pend_o(pend), .circ_base_o(circ_base), .circ_top_o(circ_top),
        .circ_wptr_o(circ_wptr), .circ_arm_o(circ_arm)
    );

    cmdq_fetch_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .circ_i(circ_mode),
        .ld_valid_i(ld_valid), .ld_start_i(ld_start), .ld_end_i(ld_end),
        .circ_base_i(circ_base), .circ_top_i(circ_top),
        .circ_wptr_i(circ_wptr), .circ_arm_i(circ_arm),
        .req_gnt_i(req_gnt_i), .req_o(req_o), .rd_ptr_o(req_addr_o),
        .idle_o(seq_idle)
    );

    cmdq_rd_snap #(.AW(AW)) u_snap (
        .clk(clk), .rst_n(rst_n), .trig_i(snap_trig_i),
        .ptr_i(req_addr_o), .snap_o(snap_addr_o)
    );

    // Purpose: busy covers active fetching and ranges that are queued.
    assign busy_o = req_o || pend;
endmodule

// File: rtl/cmdq_fetch_ptr_chk.sv
// Module: checker with temporal properties of the fetch pointer controller
// at its ports. Attached to the top by the bind statement at the end of this file.
module cmdq_fetch_ptr_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          cmd_msg_i,
    input logic          ring_move_i,
    input logic          snap_trig_i,
    input logic          req_gnt_i,
    input logic          req_o,
    input logic [AW-1:0] req_addr_o,
    input logic          busy_o,
    input logic [AW-1:0] snap_addr_o
);
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !req_gnt_i) |=> $stable(req_addr_o));

    p_linear_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd2 && req_o && req_gnt_i) |=> (req_addr_o == $past(req_addr_o) + AW'(8)));

    p_snap_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snap_trig_i |=> (snap_addr_o == $past(req_addr_o)));

    p_abs_busy_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && cmd_msg_i && busy_o) |=> busy_o);

    p_circ_no_self_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2 && !req_o && !ring_move_i) |=> !req_o);

    p_req_implies_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && req_o && !req_gnt_i) |=> busy_o);
endmodule

bind cmdq_fetch_ptr cmdq_fetch_ptr_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .cmd_msg_i(cmd_msg_i),
    .ring_move_i(ring_move_i), .snap_trig_i(snap_trig_i),
    .req_gnt_i(req_gnt_i), .req_o(req_o), .req_addr_o(req_addr_o),
    .busy_o(busy_o), .snap_addr_o(snap_addr_o)
);

// File: tb/test_cmdq_fetch_ptr.sv
`timescale 1ns/1ps
module test_cmdq_fetch_ptr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        start_set = 1'b0, cmd_msg = 1'b0, ring_move = 1'b0;
    logic        snap_trig = 1'b0, gnt = 1'b1;
    logic [31:0] start_addr = '0, end_addr = '0, offset = '0, ring_wptr = '0;
    logic        req, busy;
    logic [31:0] req_addr, snap;

    int checks = 0;
    int errors = 0;
    logic [31:0] got [0:63];
    int ngot;

    always #2 clk = ~clk;

    cmdq_fetch_ptr #(.AW(32)) i_cmdq_fetch_ptr (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .start_set_i(start_set), .start_addr_i(start_addr),
        .cmd_msg_i(cmd_msg), .end_addr_i(end_addr), .offset_i(offset),
        .ring_move_i(ring_move), .ring_wptr_i(ring_wptr),
        .snap_trig_i(snap_trig), .req_gnt_i(gnt),
        .req_o(req), .req_addr_o(req_addr), .busy_o(busy), .snap_addr_o(snap)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic        reloc;
        logic [31:0] sa;
        logic [31:0] eo;
        logic [31:0] first;
        logic [7:0]  cnt;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 1'b0, 32'h100, 32'h120, 32'h100, 8'd4},
        '{2'd0, 1'b0, 32'h800, 32'h808, 32'h800, 8'd1},
        '{2'd0, 1'b0, 32'h40,  32'h40,  32'h0,   8'd0},
        '{2'd1, 1'b1, 32'h3000, 32'h18, 32'h3000, 8'd3},
        '{2'd1, 1'b0, 32'h0,   32'h10,  32'h3018, 8'd2},
        '{2'd1, 1'b1, 32'h10,  32'h8,   32'h10,  8'd1}
    };

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic msg(input logic ss, input logic cm, input logic mv,
                       input logic [31:0] sa, input logic [31:0] ea,
                       input logic [31:0] of, input logic [31:0] wp);
        start_set = ss; cmd_msg = cm; ring_move = mv;
        start_addr = sa; end_addr = ea; offset = of; ring_wptr = wp;
        @(negedge clk);
        start_set = 1'b0; cmd_msg = 1'b0; ring_move = 1'b0;
    endtask

    task automatic drain();
        ngot = 0;
        for (int k = 0; k < 400; k++) begin
            if (req && gnt && ngot < 64) begin
                got[ngot] = req_addr;
                ngot++;
            end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req && !busy, "R1 idle after reset", {30'd0, req, busy}, 0);
        chk(snap == 0, "R1 snapshot reset", snap, 0);

        // table walk: R2 absolute ranges, R5/R7 offset ranges
        for (int v = 0; v < 6; v++) begin
            mode = VECS[v].md;
            gnt = 1'b1;
            if (VECS[v].reloc) msg(1'b1, 1'b0, 1'b0, VECS[v].sa, 0, 0, 0);
            msg(1'b0, 1'b1, 1'b0, VECS[v].sa, VECS[v].eo, VECS[v].eo, 0);
            drain();
            chk(ngot == int'(VECS[v].cnt), VECS[v].md == 0 ? "R2 count" : "R5 count", ngot, VECS[v].cnt);
            if (ngot > 0) begin
                chk(got[0] == VECS[v].first, VECS[v].reloc ? "R7 first addr" : "R5/R2 first addr", got[0], VECS[v].first);
                for (int i = 1; i < ngot; i++)
                    chk(got[i] == got[i-1] + 8, "R2 step of 8", got[i], got[i-1] + 8);
            end
        end

        // R4 stall hold and R3 newest pending range, R11 busy
        mode = 2'd0; gnt = 1'b0;
        msg(1'b0, 1'b1, 1'b0, 32'h100, 32'h140, 0, 0);
        repeat (3) @(negedge clk);
        chk(req && req_addr == 32'h100, "R4 address held under stall", req_addr, 32'h100);
        msg(1'b0, 1'b1, 1'b0, 32'h200, 32'h210, 0, 0);
        msg(1'b0, 1'b1, 1'b0, 32'h300, 32'h318, 0, 0);
        chk(busy, "R11 busy while stalled", busy, 1);
        gnt = 1'b1;
        drain();
        chk(ngot == 11, "R3 total fetches", ngot, 11);
        chk(got[8] == 32'h300 && got[10] == 32'h310, "R3 newest range ran", got[8], 32'h300);
        for (int i = 0; i < ngot; i++)
            chk(got[i][31:8] != 24'h2, "R3 dropped range not fetched", got[i], 0);

        // R6 offset accumulation, R7 start message ignored while busy
        mode = 2'd1; gnt = 1'b0;
        msg(1'b1, 1'b0, 1'b0, 32'h1000, 0, 0, 0);
        msg(1'b0, 1'b1, 1'b0, 0, 0, 32'h20, 0);
        msg(1'b0, 1'b1, 1'b0, 0, 0, 32'h10, 0);
        msg(1'b0, 1'b1, 1'b0, 0, 0, 32'h18, 0);
        msg(1'b1, 1'b0, 1'b0, 32'h5000, 0, 0, 0);
        gnt = 1'b1;
        drain();
        chk(ngot == 9, "R6 accumulated count", ngot, 9);
        chk(got[8] == 32'h1040, "R6 extension end", got[8], 32'h1040);
        for (int i = 1; i < ngot; i++)
            chk(got[i] == got[i-1] + 8, "R6 contiguous", got[i], got[i-1] + 8);
        msg(1'b0, 1'b1, 1'b0, 0, 0, 32'h10, 0);
        drain();
        chk(ngot == 2 && got[0] == 32'h1048, "R7 busy relocation ignored", got[0], 32'h1048);

        // R8 circular operation, R9 wrap
        mode = 2'd2; gnt = 1'b1;
        msg(1'b1, 1'b0, 1'b0, 32'h2000, 0, 0, 0);
        msg(1'b0, 1'b1, 1'b0, 0, 32'h2040, 0, 0);
        chk(!req, "R8 no fetch before move", req, 0);
        msg(1'b0, 1'b0, 1'b1, 0, 0, 0, 32'h2030);
        drain();
        chk(ngot == 6 && got[0] == 32'h2000, "R8 first circular run", got[0], 32'h2000);
        chk(got[5] == 32'h2028, "R8 stop at producer", got[5], 32'h2028);
        msg(1'b0, 1'b0, 1'b1, 0, 0, 0, 32'h2010);
        drain();
        chk(ngot == 4, "R9 wrap count", ngot, 4);
        chk(got[1] == 32'h2038 && got[2] == 32'h2000, "R9 wrap to base", got[2], 32'h2000);
        chk(got[3] == 32'h2008 && !req, "R9 stop after wrap", got[3], 32'h2008);

        // R10 snapshot, including the cycle of a grant
        gnt = 1'b0;
        msg(1'b0, 1'b0, 1'b1, 0, 0, 0, 32'h2020);
        chk(req && req_addr == 32'h2010, "R10 setup address", req_addr, 32'h2010);
        gnt = 1'b1; snap_trig = 1'b1;
        @(negedge clk);
        gnt = 1'b0; snap_trig = 1'b0;
        chk(snap == 32'h2010, "R10 snapshot equals granted address", snap, 32'h2010);
        chk(req_addr == 32'h2018, "R10 pointer advanced", req_addr, 32'h2018);
        snap_trig = 1'b1;
        @(negedge clk);
        snap_trig = 1'b0;
        chk(snap == 32'h2018, "R10 snapshot while stalled", snap, 32'h2018);
        gnt = 1'b1;
        drain();
        chk(ngot == 1 && !busy, "R8 final drain", ngot, 1);

        // R1 reset mid-operation
        gnt = 1'b0;
        msg(1'b0, 1'b0, 1'b1, 0, 0, 0, 32'h2030);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(!req && !busy && snap == 0, "R1 reset clears state", {31'd0, busy}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule